// File: doc/BRIEF.md
# Modem Status Change Register

This block watches four active-low modem handshake lines: carrier detect, ring indicator, data set ready and clear to send. It reports their present levels in the upper half of a status byte and records, in the lower half, which lines have changed since software last read that byte. Each pin first passes through a synchronizer chain whose length is a parameter.

Three of the change flags record a transition in either direction. The ring flag records only the end of a ring, when the pin goes from low back to high. Reading the status byte returns the flags and clears them in the same clock. A transition that lands in the clearing cycle is still recorded. An interrupt request is raised while any flag is set and an enable input allows it.

A plain scratch byte shares the same read/write port. Reads have one cycle of latency.

Top module: `modem_status_block`

## Requirements
- R1: A status read returns the inverted synchronized pin levels in bits 7 (carrier detect), 6 (ring), 5 (data set ready) and 4 (clear to send). Each pin reaches these bits through SYNC_STAGES flops.
- R2: Bit 3 (carrier detect), bit 1 (data set ready) and bit 0 (clear to send) set on either edge of their synchronized pin.
- R3: Bit 2 sets only when the synchronized ring pin goes from low to high. A high-to-low transition leaves it unchanged.
- R4: A set flag stays set, through any number of further pin changes, until a status read.
- R5: The status byte sits at address 6 and the scratch byte at address 7. Read data appears on bus_rdata in the cycle after the strobe. That data is the value held before the strobe's edge. A status read clears all four flags at that same edge. Without a read strobe, or at any other address, bus_rdata is 0.
- R6: A change that is detected on the same edge as a clearing status read leaves its flag set.
- R7: irq is high exactly while irq_en is high and at least one flag is set.
- R8: Reset clears the flags, the scratch byte and bus_rdata. No flag sets during the first SYNC_STAGES+1 cycles after reset.
- R9: A write to address 7 stores bus_wdata in the scratch byte. A write to address 6 changes neither the flags nor the levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dsr_n | input | 1 | Data set ready pin, active low, asynchronous |
| cts_n | input | 1 | Clear to send pin, active low, asynchronous |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_en | input | 1 | Modem-status interrupt enable |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2 and keeps the default address map. The longer chain moves the arming window to four cycles and separates the pin-to-flag delay from the read latency. This makes a read strobe placed exactly on the detection edge a case that is deliberately distinct from its neighbours. Directed reads check the both-edge flags, the trailing-edge-only ring flag, the read-and-clear collision and the scratch byte. A random phase then compares every cycle against a behavioural model.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;

    localparam int LINE_CNT = 4;
    localparam int BYTE_W   = 8;

    typedef logic [LINE_CNT-1:0] line_vec_t;
    typedef logic [BYTE_W-1:0]   byte_t;

    // bit positions of each line inside both halves of the status byte
    typedef enum logic [1:0] {
        LN_CTS = 2'd0,
        LN_DSR = 2'd1,
        LN_RI  = 2'd2,
        LN_DCD = 2'd3
    } line_idx_e;

    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_RISE = 1'b1
    } edge_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_STATUS  = 2'd1,
        SEL_SCRATCH = 2'd2
    } reg_sel_e;

    typedef struct packed {
        line_vec_t level;   // upper nibble: active-high line levels
        line_vec_t delta;   // lower nibble: sticky change flags
    } status_byte_t;

    // pins are active low, so a rise of the raw pin ends a ring
    function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
        logic hit;
        if (mode == EDGE_RISE) hit = ~prev & cur;
        else                   hit = prev ^ cur;
        return hit;
    endfunction

    function automatic line_vec_t rise_only_mask();
        return line_vec_t'(1) << LN_RI;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import modem_stat_pkg::*;
#(
    parameter int               WIDTH      = LINE_CNT,
    parameter logic [WIDTH-1:0] RISE_MASK  = '0,
    parameter int               ARM_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    input  logic             clr,
    output logic [WIDTH-1:0] flags,
    output logic [WIDTH-1:0] set_hits,
    output logic             armed
);

    localparam int CW = $clog2(ARM_CYCLES + 1);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] flags_q;
    logic [CW-1:0]    warm_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= cur;
    end

    // the chain holds reset values for a while; ignore edges until it is filled
    always_ff @(posedge clk) begin
        if (rst)                           warm_q <= '0;
        else if (warm_q != CW'(ARM_CYCLES)) warm_q <= warm_q + 1'b1;
    end

    assign armed = (warm_q == CW'(ARM_CYCLES));

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        if (RISE_MASK[g]) begin : g_rise
            assign hit[g] = edge_hit(EDGE_RISE, prev_q[g], cur[g]);
        end else begin : g_any
            assign hit[g] = edge_hit(EDGE_ANY, prev_q[g], cur[g]);
        end
    end

    assign set_hits = armed ? hit : '0;

    // a new hit wins over the clearing read
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (clr ? '0 : flags_q) | set_hits;
    end

    assign flags = flags_q;

endmodule

// File: rtl/msr_regs.sv
module msr_regs
    import modem_stat_pkg::*;
#(
    parameter int                ADDR_W       = 3,
    parameter logic [ADDR_W-1:0] STATUS_ADDR  = 6,
    parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  byte_t             bus_wdata,
    input  status_byte_t      status_now,
    output byte_t             rdata,
    output logic              clr_stb,
    output byte_t             scratch_val
);

    reg_sel_e sel;
    byte_t    rdata_q;
    byte_t    scratch_q;

    always_comb begin
        if (bus_addr == STATUS_ADDR)       sel = SEL_STATUS;
        else if (bus_addr == SCRATCH_ADDR) sel = SEL_SCRATCH;
        else                               sel = SEL_NONE;
    end

    assign clr_stb = bus_rd && (sel == SEL_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_STATUS:  rdata_q <= status_now;
                SEL_SCRATCH: rdata_q <= scratch_q;
                default:     rdata_q <= '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               scratch_q <= '0;
        else if (bus_wr && sel == SEL_SCRATCH) scratch_q <= bus_wdata;
    end

    assign rdata       = rdata_q;
    assign scratch_val = scratch_q;

endmodule

// File: rtl/modem_status_block.sv
module modem_status_block
    import modem_stat_pkg::*;
#(
    parameter int                SYNC_STAGES  = 2,
    parameter int                ADDR_W       = 3,
    parameter logic [ADDR_W-1:0] STATUS_ADDR  = 6,
    parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dcd_n,
    input  logic              ri_n,
    input  logic              dsr_n,
    input  logic              cts_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              irq_en,
    output logic              irq
);

    localparam int ARM_CYCLES = SYNC_STAGES + 1;

    line_vec_t    pins_n;
    line_vec_t    sync_lines;
    line_vec_t    flags_q;
    line_vec_t    flag_set;
    logic         armed;
    logic         clr_stb;
    byte_t        scratch_val;
    status_byte_t status_now;

    assign pins_n = {dcd_n, ri_n, dsr_n, cts_n};

    msr_sync #(
        .WIDTH   (LINE_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_n),
        .q   (sync_lines)
    );

    msr_delta #(
        .WIDTH      (LINE_CNT),
        .RISE_MASK  (rise_only_mask()),
        .ARM_CYCLES (ARM_CYCLES)
    ) u_delta (
        .clk      (clk),
        .rst      (rst),
        .cur      (sync_lines),
        .clr      (clr_stb),
        .flags    (flags_q),
        .set_hits (flag_set),
        .armed    (armed)
    );

    assign status_now = '{level: ~sync_lines, delta: flags_q};

    msr_regs #(
        .ADDR_W       (ADDR_W),
        .STATUS_ADDR  (STATUS_ADDR),
        .SCRATCH_ADDR (SCRATCH_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .status_now  (status_now),
        .rdata       (bus_rdata),
        .clr_stb     (clr_stb),
        .scratch_val (scratch_val)
    );

    assign irq = irq_en & (|flags_q);

endmodule

// File: rtl/modem_status_chk.sv
module modem_status_chk #(
    parameter int                ADDR_W       = 3,
    parameter logic [ADDR_W-1:0] STATUS_ADDR  = 6,
    parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              irq_en,
    input logic              irq,
    input logic [3:0]        sync_lines,
    input logic [3:0]        flags_q,
    input logic [3:0]        flag_set,
    input logic              armed,
    input logic              clr_stb,
    input logic [7:0]        scratch_val
);

    logic rd_status;
    logic wr_scratch;
    assign rd_status  = bus_rd && (bus_addr == STATUS_ADDR);
    assign wr_scratch = bus_wr && (bus_addr == SCRATCH_ADDR);

    p_levels_r1: assert property (@(posedge clk) disable iff (rst)
        rd_status |=> (bus_rdata[7:4] == ~$past(sync_lines)));

    p_ring_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[2]) |-> ($past(sync_lines[2]) && !$past(sync_lines[2], 2)));

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !clr_stb |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> ((flags_q & ~$past(flag_set)) == 4'h0));

    p_idle_rdata_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 8'h00));

    p_keep_on_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && flag_set != 4'h0) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags_q != 4'h0));

    p_quiet_warmup_r8: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (flags_q == 4'h0));

    p_scratch_store_r9: assert property (@(posedge clk) disable iff (rst)
        wr_scratch |=> (scratch_val == $past(bus_wdata)));

endmodule

bind modem_status_block modem_status_chk #(
    .ADDR_W       (ADDR_W),
    .STATUS_ADDR  (STATUS_ADDR),
    .SCRATCH_ADDR (SCRATCH_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_en      (irq_en),
    .irq         (irq),
    .sync_lines  (sync_lines),
    .flags_q     (flags_q),
    .flag_set    (flag_set),
    .armed       (armed),
    .clr_stb     (clr_stb),
    .scratch_val (scratch_val)
);

// File: tb/modem_status_block_test.sv
`timescale 1ns/1ps
module modem_status_block_test;

    localparam int       S    = 3;
    localparam logic [2:0] STA = 3'd6;
    localparam logic [2:0] SCR = 3'd7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pins = 4'hF;      // {dcd_n, ri_n, dsr_n, cts_n}
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_en = 1'b0;
    logic       irq;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R8";

    always #2 clk = ~clk;

    modem_status_block #(
        .SYNC_STAGES (S),
        .ADDR_W      (3),
        .STATUS_ADDR (STA),
        .SCRATCH_ADDR(SCR)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .dcd_n     (pins[3]),
        .ri_n      (pins[2]),
        .dsr_n     (pins[1]),
        .cts_n     (pins[0]),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_en    (irq_en),
        .irq       (irq)
    );

    // behavioural reference
    logic [3:0] hist[$];
    logic [3:0] m_flags;
    logic [7:0] m_scratch;
    logic [7:0] m_rdata;
    int         n_edges;

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [3:0] s;
        logic [3:0] pv;
        logic [3:0] set;
        if (rst) begin
            hist = {};
            for (int i = 0; i <= S; i++) hist.push_back(4'hF);
            m_flags = 4'h0; m_scratch = 8'h00; m_rdata = 8'h00; n_edges = 0;
        end else begin
            n_edges++;
            s  = hist[1];
            pv = hist[0];
            set    = (s ^ pv) & 4'b1011;
            set[2] = s[2] & ~pv[2];
            if (n_edges <= S + 1) set = 4'h0;
            if (bus_rd && bus_addr == STA)      m_rdata = {~s, m_flags};
            else if (bus_rd && bus_addr == SCR) m_rdata = m_scratch;
            else                                m_rdata = 8'h00;
            if (bus_rd && bus_addr == STA) m_flags = set;
            else                           m_flags = m_flags | set;
            if (bus_wr && bus_addr == SCR) m_scratch = bus_wdata;
            void'(hist.pop_front());
            hist.push_back(pins);
        end
        #1;
        check8(cur_tag, bus_rdata, m_rdata);
        check8("R7", {7'd0, irq}, {7'd0, irq_en & (|m_flags)});
    end

    task automatic read_expect(logic [2:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        check8(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic write_reg(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_pins(logic [3:0] v, int settle);
        @(negedge clk);
        pins = v;
        repeat (settle) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        // R8: no flags after reset, R1: all lines inactive
        read_expect(STA, 8'h00, "R8");
        cur_tag = "R2";
        set_pins(4'b1110, 6);                // cts asserted
        read_expect(STA, 8'h11, "R2");
        read_expect(STA, 8'h10, "R5");       // cleared by previous read
        cur_tag = "R3";
        set_pins(4'b1010, 6);                // ring starts: no flag
        read_expect(STA, 8'h50, "R3");
        set_pins(4'b1110, 6);                // ring ends: flag
        read_expect(STA, 8'h14, "R3");
        cur_tag = "R4";
        set_pins(4'b0110, 6);
        set_pins(4'b1110, 6);
        read_expect(STA, 8'h18, "R4");       // sticky through two changes
        cur_tag = "R2";
        set_pins(4'b1100, 6);
        read_expect(STA, 8'h32, "R2");
        read_expect(STA, 8'h30, "R1");
        cur_tag = "R7";
        irq_en = 1'b0;
        set_pins(4'b1101, 6);
        check8("R7", {7'd0, irq}, 8'h00);
        @(negedge clk); irq_en = 1'b1;
        @(negedge clk);
        check8("R7", {7'd0, irq}, 8'h01);
        read_expect(STA, 8'h21, "R7");
        check8("R7", {7'd0, irq}, 8'h00);
        cur_tag = "R6";
        @(negedge clk); pins = 4'b1100;      // change hits on the read edge
        repeat (S - 1) @(negedge clk);
        read_expect(STA, 8'h30, "R6");
        read_expect(STA, 8'h31, "R6");
        read_expect(STA, 8'h30, "R6");
        cur_tag = "R9";
        write_reg(SCR, 8'hA5);
        read_expect(SCR, 8'hA5, "R9");
        write_reg(STA, 8'hFF);
        read_expect(STA, 8'h30, "R9");
        read_expect(SCR, 8'hA5, "R9");
        read_expect(3'd2, 8'h00, "R5");
        cur_tag = "R8";
        set_pins(4'b1101, 6);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        read_expect(SCR, 8'h00, "R8");
        read_expect(STA, 8'h20, "R8");
        cur_tag = "R5";
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if ($urandom_range(0, 5) == 0) pins = 4'($urandom);
            bus_rd    = ($urandom_range(0, 2) == 0);
            bus_wr    = ($urandom_range(0, 4) == 0);
            bus_addr  = ($urandom_range(0, 3) == 0) ? 3'($urandom) : (($urandom_range(0, 1) == 0) ? STA : SCR);
            bus_wdata = 8'($urandom);
            irq_en    = ($urandom_range(0, 3) != 0);
        end
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule